// File: doc/BRIEF.md
# Buck Channel Switching-Mode Controller

This block decides which switching mode one synchronous buck regulator channel runs in. A 4-bit mode code, written by the host or reloaded from a power-up default by the start-up sequencer, is decoded against a standby pin. The decode gives a target mode of OFF, PFM, APS or PWM. Whenever the channel is off, the block drives a discharge-enable so that the output rail is bled down.

Each time the channel is brought up, the controller walks through a fixed soft-start order before it applies the target. It runs PFM for a set number of cycles, then APS for the same count, then PWM. It stays in PWM until the analog loop reports regulation. It then parks in APS, the channel's default on-mode, for a settle window that is counted in system clock cycles (about 3 ms). Only after that window does it hand over to the programmed mode. If regulation drops during the window, the controller returns to PWM and the count restarts.

Codes that have no meaning leave the last valid target in place and raise a sticky error flag. All inputs are plain level or strobe controls. No streaming data passes through the block, so it has no handshake.

Top module: `buck_mode_ctrl`

## Requirements
- R1: The `mode` output encodes OFF=0, PFM=1, APS=2, PWM=3. `discharge` is high exactly when `mode` is OFF.
- R2: While `rst_n` is low (synchronous), `mode` is OFF, `discharge` is 1 and `code_err` is 0. The mode code register loads `pwr_default`.
- R3: Every bring-up starts from OFF with PFM for STEP_CYC cycles, then APS for STEP_CYC cycles, then PWM. PWM holds for as long as `reg_ok` stays low.
- R4: In the PWM step, a sampled `reg_ok` moves the channel to APS for SETTLE_CYC cycles, after which the decoded target is applied. If `reg_ok` falls during that window, the channel returns to PWM and a later rise starts a full window again.
- R5: With `standby` low, code 4'b0000 gives OFF, 4'b0001 gives PWM and 4'b0011 gives PFM. A new code written while the channel is running shows on `mode` two clock edges after the write strobe.
- R6: With `standby` high, codes 4'b0000, 4'b0001 and 4'b0011 all give OFF.
- R7: Code 4'b0010 and all codes 4'b0100 to 4'b1111 are reserved. They keep the previous target and set `code_err`. `code_err` then stays high until an `err_clr` strobe arrives while a valid code is held.
- R8: A `seq_rst` strobe reloads the code register from `pwr_default`, and it overrides a host write in the same cycle.
- R9: With `enable` low, `mode` is OFF from the next clock edge on, whatever state the channel was in.
- R10: A target of OFF ends soft-start or run. A later non-OFF target brings the channel up again through the full soft-start order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_rst | input | 1 | Start-up sequencer strobe: reload code from default |
| pwr_default | input | 4 | Power-up default mode code |
| wr_en | input | 1 | Host write strobe for the mode code |
| wr_code | input | 4 | Mode code written by the host |
| standby | input | 1 | Standby pin, high selects standby decoding |
| enable | input | 1 | Channel enable |
| reg_ok | input | 1 | Output-in-regulation flag from the analog loop |
| err_clr | input | 1 | Clears the sticky code error |
| mode | output | 2 | Active switching mode |
| discharge | output | 1 | Output discharge enable |
| code_err | output | 1 | Sticky reserved-code flag |

## Verification
Bring-up is run with three targets: PWM from the power-up default, PFM after an OFF code, and PWM after a standby exit. The step lengths are measured in each case. The runs therefore show a real soft-start walk apart from a jump straight to the target, and the PFM target shows apart from the first PFM step. The settle window is run once without a break and once with `reg_ok` dropped halfway, which shows whether the count restarts or resumes. Codes are applied under both standby levels and include reserved values, so the held previous target can be told apart from a forced OFF.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    MD_OFF = 2'd0,
    MD_PFM = 2'd1,
    MD_APS = 2'd2,
    MD_PWM = 2'd3
  } sw_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SS_PFM,
    ST_SS_APS,
    ST_SS_PWM,
    ST_SETTLE,
    ST_RUN
  } seq_state_e;

  typedef struct packed {
    logic     valid;
    sw_mode_e mode;
  } decode_t;

  // Map a mode code to a target under normal or standby decoding.
  function automatic decode_t decode_code(input logic [CODE_W-1:0] code,
                                          input logic stby);
    decode_t d;
    d.valid = 1'b1;
    d.mode  = MD_OFF;
    case (code)
      4'b0000: d.mode = MD_OFF;
      4'b0001: d.mode = stby ? MD_OFF : MD_PWM;
      4'b0011: d.mode = stby ? MD_OFF : MD_PFM;
      default: d.valid = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cycle_timer.sv
module cycle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (cnt != CNT_MAX)
      cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/mode_code_reg.sv
module mode_code_reg
  import buck_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_rst,
  input  logic [CODE_W-1:0] pwr_default,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              standby,
  input  logic              err_clr,
  output sw_mode_e          target,
  output logic              code_err
);

  logic [CODE_W-1:0] code_q;
  decode_t           dec;

  always_comb dec = decode_code(code_q, standby);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= pwr_default;
      target   <= MD_OFF;
      code_err <= 1'b0;
    end else begin
      if (seq_rst)
        code_q <= pwr_default;
      else if (wr_en)
        code_q <= wr_code;
      if (dec.valid)
        target <= dec.mode;
      code_err <= !dec.valid || (code_err && !err_clr);
    end
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import buck_mode_pkg::*;
#(
  parameter int STEP_CYC   = 32,
  parameter int SETTLE_CYC = 96000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     reg_ok,
  input  sw_mode_e target,
  output sw_mode_e mode,
  output logic     discharge
);

  localparam int LONGEST = (STEP_CYC > SETTLE_CYC) ? STEP_CYC : SETTLE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam logic [CNT_W-1:0] STEP_LAST   = CNT_W'(STEP_CYC - 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

  seq_state_e       state, nxt;
  logic [CNT_W-1:0] cnt;
  logic             step_done, settle_done, tgt_off, leave;

  cycle_timer #(.CNT_W(CNT_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (leave),
    .cnt   (cnt)
  );

  assign step_done   = (cnt == STEP_LAST);
  assign settle_done = (cnt == SETTLE_LAST);
  assign tgt_off     = (target == MD_OFF);

  always_comb begin
    nxt = state;
    if (!enable) begin
      nxt = ST_OFF;
    end else begin
      case (state)
        ST_OFF:    if (!tgt_off) nxt = ST_SS_PFM;
        ST_SS_PFM: if (tgt_off) nxt = ST_OFF;
                   else if (step_done) nxt = ST_SS_APS;
        ST_SS_APS: if (tgt_off) nxt = ST_OFF;
                   else if (step_done) nxt = ST_SS_PWM;
        ST_SS_PWM: if (tgt_off) nxt = ST_OFF;
                   else if (reg_ok) nxt = ST_SETTLE;
        ST_SETTLE: if (tgt_off) nxt = ST_OFF;
                   else if (!reg_ok) nxt = ST_SS_PWM;
                   else if (settle_done) nxt = ST_RUN;
        ST_RUN:    if (tgt_off) nxt = ST_OFF;
        default:   nxt = ST_OFF;
      endcase
    end
  end

  assign leave = (nxt != state);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end

  always_comb begin
    case (state)
      ST_SS_PFM: mode = MD_PFM;
      ST_SS_APS: mode = MD_APS;
      ST_SS_PWM: mode = MD_PWM;
      ST_SETTLE: mode = MD_APS;
      ST_RUN:    mode = target;
      default:   mode = MD_OFF;
    endcase
  end

  assign discharge = (state == ST_OFF) || (state == ST_RUN && tgt_off);

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_mode_pkg::*;
#(
  parameter int STEP_CYC   = 32,
  parameter int SETTLE_CYC = 96000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_rst,
  input  logic [3:0] pwr_default,
  input  logic       wr_en,
  input  logic [3:0] wr_code,
  input  logic       standby,
  input  logic       enable,
  input  logic       reg_ok,
  input  logic       err_clr,
  output logic [1:0] mode,
  output logic       discharge,
  output logic       code_err
);

  sw_mode_e target, mode_e;

  mode_code_reg code_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_rst     (seq_rst),
    .pwr_default (pwr_default),
    .wr_en       (wr_en),
    .wr_code     (wr_code),
    .standby     (standby),
    .err_clr     (err_clr),
    .target      (target),
    .code_err    (code_err)
  );

  softstart_seq #(
    .STEP_CYC   (STEP_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .reg_ok    (reg_ok),
    .target    (target),
    .mode      (mode_e),
    .discharge (discharge)
  );

  assign mode = mode_e;

endmodule

// File: rtl/buck_mode_ctrl_chk.sv
module buck_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       reg_ok,
  input logic       err_clr,
  input logic [1:0] mode,
  input logic       discharge,
  input logic       code_err
);

  AST_DISCHARGE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    discharge == (mode == 2'd0)); // R1

  AST_START_AT_PFM: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd0 && mode != 2'd0) |-> mode == 2'd1); // R3

  AST_SETTLE_NEEDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3 && mode == 2'd2) |-> $past(reg_ok)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code_err) && !$past(err_clr)) |-> code_err); // R7

  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> mode == 2'd0); // R9

endmodule

bind buck_mode_ctrl buck_mode_ctrl_chk chk_i (.*);

// File: tb/buck_mode_ctrl_tb_top.sv
module buck_mode_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP       = 4;
  localparam int SETTLE     = 20;
  localparam logic [1:0] M_OFF = 2'd0, M_PFM = 2'd1, M_APS = 2'd2, M_PWM = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0, seq_rst = 1'b0, wr_en = 1'b0, standby = 1'b0;
  logic enable = 1'b0, reg_ok = 1'b0, err_clr = 1'b0;
  logic [3:0] pwr_default = 4'b0001, wr_code = 4'b0000;
  logic [1:0] mode;
  logic discharge, code_err;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_mode_ctrl #(.STEP_CYC(STEP), .SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .seq_rst(seq_rst), .pwr_default(pwr_default),
    .wr_en(wr_en), .wr_code(wr_code), .standby(standby), .enable(enable),
    .reg_ok(reg_ok), .err_clr(err_clr), .mode(mode), .discharge(discharge),
    .code_err(code_err));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_code(input logic [3:0] c);
    wr_en = 1'b1; wr_code = c;
    tick(1);
    wr_en = 1'b0;
    tick(1);
  endtask

  task automatic wait_mode(input logic [1:0] m, input string req);
    int n = 0;
    while (mode != m && n < 200) begin n++; tick(1); end
    chk(req, int'(mode), int'(m));
  endtask

  task automatic count_mode(input logic [1:0] m, output int n);
    n = 0;
    while (mode == m && n < 200) begin n++; tick(1); end
  endtask

  // Full bring-up from OFF to the run mode exp_run; reg_ok must be low.
  task automatic bring_up(input logic [1:0] exp_run, input string req);
    int n;
    wait_mode(M_PFM, {req, " R3 first PFM"});
    count_mode(M_PFM, n);  chk("R3 PFM step length", n, STEP);
    count_mode(M_APS, n);  chk("R3 APS step length", n, STEP);
    tick(10);
    chk("R3 PWM held without reg_ok", int'(mode), int'(M_PWM));
    reg_ok = 1'b1;
    tick(1);
    count_mode(M_APS, n);  chk("R4 settle length", n, SETTLE);
    chk({req, " R4 run mode"}, int'(mode), int'(exp_run));
  endtask

  task automatic t_reset();
    tick(3);
    chk("R2 reset mode", int'(mode), int'(M_OFF));
    chk("R2 reset discharge", int'(discharge), 1);
    chk("R2 reset code_err", int'(code_err), 0);
    rst_n = 1'b1; enable = 1'b1;
  endtask

  task automatic t_bringup();
    bring_up(M_PWM, "R2 default code");
    chk("R1 no discharge in run", int'(discharge), 0);
  endtask

  task automatic t_decode();
    write_code(4'b0011); chk("R5 code 0011", int'(mode), int'(M_PFM));
    write_code(4'b0001); chk("R5 code 0001", int'(mode), int'(M_PWM));
    write_code(4'b0000); chk("R5 code 0000", int'(mode), int'(M_OFF));
    chk("R1 discharge on OFF", int'(discharge), 1);
    reg_ok = 1'b0;
    tick(3);
    chk("R10 stays OFF", int'(mode), int'(M_OFF));
    write_code(4'b0011);
    bring_up(M_PFM, "R10 restart");
  endtask

  task automatic t_settle_loss();
    int n;
    enable = 1'b0; tick(1);
    chk("R9 disable from run", int'(mode), int'(M_OFF));
    reg_ok = 1'b0; enable = 1'b1;
    wait_mode(M_PWM, "R3 reach PWM");
    reg_ok = 1'b1; tick(1);
    count_mode(M_APS, n);
    if (n != 0) ; // placeholder-free: count consumed full window below
    chk("R4 uninterrupted settle", n, SETTLE);
    enable = 1'b0; reg_ok = 1'b0; tick(1);
    enable = 1'b1;
    wait_mode(M_PWM, "R3 reach PWM again");
    reg_ok = 1'b1; tick(1 + SETTLE/2);
    chk("R4 mid-settle APS", int'(mode), int'(M_APS));
    reg_ok = 1'b0; tick(1);
    chk("R4 loss returns to PWM", int'(mode), int'(M_PWM));
    tick(2);
    reg_ok = 1'b1; tick(1);
    count_mode(M_APS, n);
    chk("R4 restarted settle", n, SETTLE);
    chk("R4 run after restart", int'(mode), int'(M_PFM));
  endtask

  task automatic t_standby();
    standby = 1'b1; tick(2);
    chk("R6 standby on 0011", int'(mode), int'(M_OFF));
    chk("R6 standby discharge", int'(discharge), 1);
    write_code(4'b0001); tick(1);
    chk("R6 standby on 0001", int'(mode), int'(M_OFF));
    write_code(4'b0000); tick(1);
    chk("R6 standby on 0000", int'(mode), int'(M_OFF));
    write_code(4'b0001);
    reg_ok = 1'b0; standby = 1'b0;
    bring_up(M_PWM, "R10 standby exit");
  endtask

  task automatic t_reserved();
    write_code(4'b0010);
    chk("R7 0010 holds mode", int'(mode), int'(M_PWM));
    chk("R7 0010 sets err", int'(code_err), 1);
    write_code(4'b1100);
    chk("R7 1100 holds mode", int'(mode), int'(M_PWM));
    err_clr = 1'b1; tick(1); err_clr = 1'b0;
    chk("R7 clr ignored while reserved", int'(code_err), 1);
    write_code(4'b0011);
    chk("R7 valid after reserved", int'(mode), int'(M_PFM));
    chk("R7 err still sticky", int'(code_err), 1);
    err_clr = 1'b1; tick(1); err_clr = 1'b0;
    chk("R7 err cleared", int'(code_err), 0);
  endtask

  task automatic t_seqrst();
    seq_rst = 1'b1; wr_en = 1'b1; wr_code = 4'b0000;
    tick(1);
    seq_rst = 1'b0; wr_en = 1'b0;
    tick(1);
    chk("R8 default reload wins", int'(mode), int'(M_PWM));
  endtask

  task automatic t_enable_ss();
    enable = 1'b0; reg_ok = 1'b0; tick(1);
    enable = 1'b1;
    wait_mode(M_PFM, "R3 restart PFM");
    tick(1);
    enable = 1'b0; tick(1);
    chk("R9 disable in soft-start", int'(mode), int'(M_OFF));
    chk("R9 discharge in soft-start", int'(discharge), 1);
  endtask

  initial begin
    t_reset();
    t_bringup();
    t_decode();
    t_settle_loss();
    t_standby();
    t_reserved();
    t_seqrst();
    t_enable_ss();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule